// File: doc/BRIEF.md
# Address-Event Link Receiver and Classifier

This block terminates an asynchronous address-event link that uses a four-phase request/acknowledge handshake and a 10-bit address. It passes the incoming request through a two-stage synchronizer. When the synchronized request is first seen high, it captures the address on that clock edge and classifies the event.

A classified event is offered to internal logic over a valid/ready port. The port carries an event kind, an 8-bit index, a signed 4-bit weight and a routing flag. The flag separates events that must be queued for later from events that are handled directly. The link is acknowledged only after the internal side has taken the event. The acknowledge is withdrawn once the sender's request is seen low again.

The two top address bits form the prefix. Prefix `10` is a virtual event. Prefix `01` is a leak event, which becomes a broadcast when the low byte is all ones. Prefix `00` is a spike. Prefix `11` carries no meaning: it is acknowledged and dropped.

Top module: `aer_rx_decoder`

## Requirements
- R1: While `rst` is high and on the first clock after it falls, `aer_ack_o` and `evt_valid_o` are both low.
- R2: If the request rises between two clock edges, no output responds at the first or second following edge. At the third edge either `evt_valid_o` rises, for a defined prefix, or `aer_ack_o` rises, for prefix `11`.
- R3: Prefix `10` (address bits 9:8) gives kind code 1 (virtual) and routing flag 1. The index is address bits 3:0 zero-extended to 8 bits, and the weight is address bits 7:4 read as two's complement.
- R4: Prefix `01` with low byte `0xFF` gives kind code 3 (leak all). The index is 0, the weight is 0 and the routing flag is 0.
- R5: Prefix `01` with any other low byte gives kind code 2 (leak one). The index is the low byte, the weight is 0 and the routing flag is 0.
- R6: Prefix `00` gives kind code 0 (spike), with the low byte as index, weight 0 and routing flag 1. A low byte of `0xFF` has no special meaning for this prefix.
- R7: While `evt_ready_i` is low, `evt_valid_o` stays high, the payload stays constant and `aer_ack_o` stays low. `aer_ack_o` rises on the edge where valid and ready are both high, and valid falls on that same edge.
- R8: `aer_ack_o` stays high while the request stays high. It falls on the third clock edge after the request falls.
- R9: Prefix `11` never raises `evt_valid_o`, yet the link is still acknowledged and released as in R2 and R8.
- R10: Only the address present on the capture edge counts. Changes to `aer_addr_i` after that edge do not alter the offered payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aer_req_i | input | 1 | Asynchronous link request |
| aer_addr_i | input | 10 | Link address, prefix in bits 9:8 |
| aer_ack_o | output | 1 | Link acknowledge |
| evt_valid_o | output | 1 | Classified event is offered |
| evt_ready_i | input | 1 | Internal side accepts the event |
| evt_kind_o | output | 2 | 0 spike, 1 virtual, 2 leak one, 3 leak all |
| evt_index_o | output | 8 | Neuron or pre-synaptic index |
| evt_weight_o | output | 4 | Signed weight, non-zero only for virtual events |
| evt_sched_o | output | 1 | 1 routes the event to the queue, 0 to direct processing |

## Verification
The request is raised midway between clock edges. Counting the two synchronizer stages and the state register, valid must be absent after the second edge and present after the third, and the bench samples it at exactly those falling edges. The acknowledge is due on the edge after valid and ready meet. Once the request drops, the acknowledge is due to fall at the third edge, so the bench samples it at the first, second and third falling edges that follow. Payloads are compared against a queue of expected events at the accepting cycle, a few nanoseconds after the falling edge where ready was driven, which also shows whether an address change after capture leaked into the payload.

// File: rtl/aer_rx_pkg.sv
package aer_rx_pkg;

    localparam int ADDR_W   = 10;
    localparam int IDX_W    = 8;
    localparam int WGT_W    = 4;
    localparam int VNEUR_W  = 4;
    localparam int PFX_W    = ADDR_W - IDX_W;

    localparam logic [PFX_W-1:0] PFX_SPIKE = 2'b00;
    localparam logic [PFX_W-1:0] PFX_LEAK  = 2'b01;
    localparam logic [PFX_W-1:0] PFX_VIRT  = 2'b10;

    localparam logic [IDX_W-1:0] IDX_BROADCAST = {IDX_W{1'b1}};

    typedef enum logic [1:0] {
        EVT_SPIKE    = 2'd0,
        EVT_VIRTUAL  = 2'd1,
        EVT_LEAK_ONE = 2'd2,
        EVT_LEAK_ALL = 2'd3
    } evt_kind_e;

    typedef struct packed {
        evt_kind_e               kind;
        logic [IDX_W-1:0]        index;
        logic signed [WGT_W-1:0] weight;
        logic                    to_sched;
    } evt_t;

    typedef struct packed {
        logic defined;
        evt_t evt;
    } dec_t;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_OFFER = 2'd1,
        HS_ACK   = 2'd2
    } hs_state_e;

    // Classify one raw link address.
    function automatic dec_t classify(input logic [ADDR_W-1:0] a);
        dec_t d;
        logic [IDX_W-1:0] low;
        low = a[IDX_W-1:0];
        d = '0;
        d.defined = 1'b1;
        unique case (a[ADDR_W-1 -: PFX_W])
            PFX_VIRT: begin
                d.evt.kind     = EVT_VIRTUAL;
                d.evt.index    = IDX_W'(a[VNEUR_W-1:0]);
                d.evt.weight   = a[VNEUR_W+WGT_W-1:VNEUR_W];
                d.evt.to_sched = 1'b1;
            end
            PFX_LEAK: begin
                if (low == IDX_BROADCAST) begin
                    d.evt.kind  = EVT_LEAK_ALL;
                    d.evt.index = '0;
                end else begin
                    d.evt.kind  = EVT_LEAK_ONE;
                    d.evt.index = low;
                end
                d.evt.to_sched = 1'b0;
            end
            PFX_SPIKE: begin
                d.evt.kind     = EVT_SPIKE;
                d.evt.index    = low;
                d.evt.to_sched = 1'b1;
            end
            default: begin
                d.defined = 1'b0;
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/aer_rx_sync.sv
module aer_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/aer_rx_classify.sv
module aer_rx_classify
    import aer_rx_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output dec_t              dec_o
);
    always_comb begin
        dec_o = classify(addr_i);
    end
endmodule

// File: rtl/aer_rx_hs_fsm.sv
module aer_rx_hs_fsm
    import aer_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_sync_i,
    input  dec_t dec_i,
    input  logic ready_i,
    output logic valid_o,
    output logic ack_o,
    output evt_t evt_o
);
    hs_state_e state;
    evt_t      held;

    // The decoded event is captured on the edge where the synchronized
    // request is first seen, so later address changes are ignored.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= HS_IDLE;
            held  <= '0;
        end else begin
            unique case (state)
                HS_IDLE: begin
                    if (req_sync_i) begin
                        held  <= dec_i.defined ? dec_i.evt : '0;
                        state <= dec_i.defined ? HS_OFFER : HS_ACK;
                    end
                end
                HS_OFFER: begin
                    if (ready_i) state <= HS_ACK;
                end
                HS_ACK: begin
                    if (!req_sync_i) state <= HS_IDLE;
                end
                default: state <= HS_IDLE;
            endcase
        end
    end

    assign valid_o = (state == HS_OFFER);
    assign ack_o   = (state == HS_ACK);
    assign evt_o   = held;
endmodule

// File: rtl/aer_rx_decoder.sv
module aer_rx_decoder
    import aer_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    aer_req_i,
    input  logic [ADDR_W-1:0]       aer_addr_i,
    output logic                    aer_ack_o,
    output logic                    evt_valid_o,
    input  logic                    evt_ready_i,
    output logic [1:0]              evt_kind_o,
    output logic [IDX_W-1:0]        evt_index_o,
    output logic signed [WGT_W-1:0] evt_weight_o,
    output logic                    evt_sched_o
);
    logic req_sync;
    dec_t dec;
    evt_t evt;

    aer_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (aer_req_i),
        .sync_o  (req_sync)
    );

    aer_rx_classify u_classify (
        .addr_i (aer_addr_i),
        .dec_o  (dec)
    );

    aer_rx_hs_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_sync_i (req_sync),
        .dec_i      (dec),
        .ready_i    (evt_ready_i),
        .valid_o    (evt_valid_o),
        .ack_o      (aer_ack_o),
        .evt_o      (evt)
    );

    assign evt_kind_o   = evt.kind;
    assign evt_index_o  = evt.index;
    assign evt_weight_o = evt.weight;
    assign evt_sched_o  = evt.to_sched;
endmodule

// File: rtl/aer_rx_checker.sv
module aer_rx_checker (
    input logic       clk,
    input logic       rst,
    input logic       req_sync,
    input logic       ack,
    input logic       valid,
    input logic       ready,
    input logic [1:0] kind,
    input logic [7:0] index,
    input logic [3:0] weight,
    input logic       sched
);
    AST_PAYLOAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        valid && !ready |=> valid && $stable(kind) && $stable(index) && $stable(weight) && $stable(sched)); // R7
    AST_NO_ACK_WHILE_OFFER: assert property (@(posedge clk) disable iff (rst)
        valid |-> !ack); // R7
    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
        ack && req_sync |=> ack); // R8
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $fell(ack) |-> !$past(req_sync)); // R8
    AST_OFFER_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> $past(req_sync)); // R2
    AST_WEIGHT_VIRT_ONLY: assert property (@(posedge clk) disable iff (rst)
        valid && kind != 2'd1 |-> weight == 4'd0); // R3
    AST_BROADCAST_INDEX: assert property (@(posedge clk) disable iff (rst)
        valid && kind == 2'd3 |-> index == 8'd0 && !sched); // R4
endmodule

bind aer_rx_decoder aer_rx_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_sync (req_sync),
    .ack      (aer_ack_o),
    .valid    (evt_valid_o),
    .ready    (evt_ready_i),
    .kind     (evt_kind_o),
    .index    (evt_index_o),
    .weight   (evt_weight_o),
    .sched    (evt_sched_o)
);

// File: tb/aer_rx_decoder_bench.sv
module aer_rx_decoder_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic       ready = 1'b0;
    logic [9:0] addr = '0;
    logic       ack, valid, sched;
    logic [1:0] kind;
    logic [7:0] index;
    logic signed [3:0] weight;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0] kind;
        logic [7:0] index;
        logic [3:0] weight;
        logic       sched;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;  // 20 ns period

    aer_rx_decoder u_aer_rx_decoder (
        .clk          (clk),
        .rst          (rst),
        .aer_req_i    (req),
        .aer_addr_i   (addr),
        .aer_ack_o    (ack),
        .evt_valid_o  (valid),
        .evt_ready_i  (ready),
        .evt_kind_o   (kind),
        .evt_index_o  (index),
        .evt_weight_o (weight),
        .evt_sched_o  (sched)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // Monitor: compare each accepted event with the head of the queue.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (!rst && valid && ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected event", int'(kind), 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(kind == e.kind,     e.tag, "kind",   int'(kind),   int'(e.kind));
                    chk(index == e.index,   e.tag, "index",  int'(index),  int'(e.index));
                    chk(weight == e.weight, e.tag, "weight", int'(weight), int'(e.weight));
                    chk(sched == e.sched,   e.tag, "sched",  int'(sched),  int'(e.sched));
                end
            end
        end
    end

    // Driver: one full four-phase transaction.
    task automatic send(input logic [9:0] a, input bit defd, input logic [1:0] k,
                        input logic [7:0] ix, input logic [3:0] w, input logic s,
                        input int stall, input string tag);
        exp_t e;
        @(negedge clk);
        addr  = a;
        req   = 1'b1;
        ready = 1'b0;
        if (defd) begin
            e.kind = k; e.index = ix; e.weight = w; e.sched = s; e.tag = tag;
            exp_q.push_back(e);
        end
        @(negedge clk);
        @(negedge clk);
        chk(!valid && !ack, "R2", "output before third edge", int'({valid, ack}), 0);
        @(negedge clk);
        if (defd) begin
            chk(valid && !ack, "R2", "valid at third edge", int'({valid, ack}), 2);
            addr = ~a;  // R10: must not reach the payload
            for (int i = 0; i < stall; i++) begin
                @(negedge clk);
                chk(valid && !ack, "R7", "held while stalled", int'({valid, ack}), 2);
            end
            ready = 1'b1;
            @(negedge clk);
            ready = 1'b0;
            chk(ack && !valid, "R7", "ack after accept", int'({valid, ack}), 1);
        end else begin
            chk(ack && !valid, "R9", "undefined prefix acked", int'({valid, ack}), 1);
        end
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk(ack && !valid, "R8", "ack held with request", int'({valid, ack}), 1);
        end
        req = 1'b0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk(ack, "R8", "ack before release edge", int'(ack), 1);
        end
        @(negedge clk);
        chk(!ack && !valid, "R8", "ack released", int'({valid, ack}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!ack && !valid, "R1", "in reset", int'({valid, ack}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!ack && !valid, "R1", "after reset", int'({valid, ack}), 0);

        send(10'h2D5, 1'b1, 2'd1, 8'h05, 4'hD, 1'b1, 0, "R3");
        send(10'h27F, 1'b1, 2'd1, 8'h0F, 4'h7, 1'b1, 2, "R3");
        send(10'h1FF, 1'b1, 2'd3, 8'h00, 4'h0, 1'b0, 1, "R4");
        send(10'h12A, 1'b1, 2'd2, 8'h2A, 4'h0, 1'b0, 0, "R5");
        send(10'h100, 1'b1, 2'd2, 8'h00, 4'h0, 1'b0, 3, "R5");
        send(10'h0FF, 1'b1, 2'd0, 8'hFF, 4'h0, 1'b1, 0, "R6");
        send(10'h037, 1'b1, 2'd0, 8'h37, 4'h0, 1'b1, 4, "R10");
        send(10'h3AB, 1'b0, 2'd0, 8'h00, 4'h0, 1'b0, 0, "R9");
        send(10'h281, 1'b1, 2'd1, 8'h01, 4'h8, 1'b1, 1, "R3");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R7", "events never delivered", exp_q.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL R8 watchdog expired: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule